// File: doc/BRIEF.md
# Indexed Register Window with Interrupt Collection

This block lets a host reach a large internal register file through four directly addressed words. A pointer word selects one of four channels and a 12-bit register address. A data word then reads or writes the indexed register that the pointer names. Each indexed address keeps a separate 32-bit word for every channel. Addresses 0x000 to 0x03F are implemented. All other addresses discard writes and read as zero.

A pending word collects single-cycle event pulses from internal sources. A host clears a pending bit by writing a one to it. An enable word masks the pending bits, and the result drives a single interrupt line. The bus bridge and the real event sources sit outside the block. Events arrive on a 32-bit pulse input. Read data is returned one cycle after the read request.

Top module: `idx_regwin`

## Requirements
- R1: After reset, the pointer, pending and enable words read as zero, `irq_o` is low, and every implemented indexed word of every channel reads as zero.
- R2: `host_addr` selects a direct word: 0 is the pointer, 1 is data, 2 is pending and 3 is enable (byte offsets 0x0, 0x4, 0x8 and 0xC). A read returns its value on `host_rdata` one cycle later, with `host_rvalid` high in that cycle.
- R3: The pointer holds the channel in bits [1:0] and the register address in bits [27:16]. Byte lane 0 updates the channel. Lane 2 updates address bits [7:0]. Lane 3 updates address bits [11:8]. Lane 1 and all other bit positions have no effect and read back as zero.
- R4: A data-word write stores all 32 bits at the selected channel and address, whatever the byte strobes are. A later data read returns that word.
- R5: The four channels keep independent words at the same address. A write to one channel leaves the other three unchanged.
- R6: At indexed addresses 0x040 to 0xFFF, writes are ignored and reads return zero. These addresses never alias onto implemented ones.
- R7: An event pulse sets its pending bit only for implemented sources: bits 0–4, 11, 16 and 17 (mask 0x0003081F). All other pending bits stay zero.
- R8: Writing a 1 to a pending bit under an active byte strobe clears that bit. Bits written with 0, or in lanes without a strobe, are unchanged.
- R9: If an event pulse and a clear of the same bit occur in the same cycle, the event wins and the bit stays set.
- R10: `irq_o` is the OR of (pending AND enable). It updates on the same clock edge as the pending or enable change that causes it. The enable word is written per byte lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write request |
| host_rd | input | 1 | Read request |
| host_addr | input | 2 | Direct word index (byte offset / 4) |
| host_wstrb | input | 4 | Byte-lane write strobes |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data, one cycle after the request |
| host_rvalid | output | 1 | Read data valid |
| evt_pulse | input | 32 | Event pulses, one bit per source |
| irq_o | output | 1 | Interrupt line |

## Verification
A wrong bank select or a truncated address compare makes a read of a neighbouring channel or an aliased address return a stale word. This shows on `host_rdata` one cycle after the read. A stuck, lost or wrongly masked pending bit appears in the next pending read, and on `irq_o` at the very edge that should have changed it. The bench therefore sweeps every channel and address, every event bit and every pointer lane. It predicts each value arithmetically.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  typedef enum logic [1:0] {
    WIN_PTR  = 2'd0,
    WIN_DATA = 2'd1,
    WIN_PEND = 2'd2,
    WIN_EN   = 2'd3
  } win_sel_e;

  function automatic logic [31:0] lanes_to_bits(input logic [3:0] strb);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{strb[i]}};
    return m;
  endfunction
endpackage

// File: rtl/regwin_ptr.sv
module regwin_ptr #(
  parameter int CH_W = 2,
  parameter int RA_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [CH_W-1:0] ch_wmask,
  input  logic [CH_W-1:0] ch_wdata,
  input  logic [RA_W-1:0] ra_wmask,
  input  logic [RA_W-1:0] ra_wdata,
  output logic [CH_W-1:0] ch_o,
  output logic [RA_W-1:0] ra_o
);
  logic [CH_W-1:0] ch_q;
  logic [RA_W-1:0] ra_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_q <= '0;
      ra_q <= '0;
    end else if (we) begin
      ch_q <= (ch_q & ~ch_wmask) | (ch_wdata & ch_wmask);
      ra_q <= (ra_q & ~ra_wmask) | (ra_wdata & ra_wmask);
    end
  end

  assign ch_o = ch_q;
  assign ra_o = ra_q;

  // R3: a pointer write without address-lane strobes keeps the address
  assert_addr_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (we && ra_wmask == '0) |=> $stable(ra_q));
  // R3: a pointer write without the channel lane keeps the channel
  assert_ch_kept_R3: assert property (@(posedge clk) disable iff (rst)
    (we && ch_wmask == '0) |=> $stable(ch_q));
endmodule

// File: rtl/regwin_bank.sv
module regwin_bank #(
  parameter int DW    = 32,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [DW-1:0] rq
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DW-1:0]    q_raw;
  logic             hit_q;

  // Plain RAM, no reset: block RAM inference
  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    if (re) q_raw <= mem[ra];
  end

  // Per-word written flags give the reset-to-zero view
  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
      hit_q <= 1'b0;
    end else begin
      if (we) vld_q[wa] <= 1'b1;
      if (re) hit_q <= vld_q[ra];
    end
  end

  assign rq = hit_q ? q_raw : '0;

  // R1: a word that was never written reads as zero
  assert_fresh_zero_R1: assert property (@(posedge clk) disable iff (rst)
    (re && !we && !vld_q[ra]) |=> (rq == '0));
endmodule

// File: rtl/regwin_irq.sv
module regwin_irq #(
  parameter int          W        = 32,
  parameter logic [31:0] SRC_MASK = 32'h0003_081F
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_pend,
  input  logic         wr_en,
  input  logic [W-1:0] bmask,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] evt,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] pend_q, en_q, pend_d, en_d, clr;
  logic         irq_q;

  always_comb begin
    clr    = wr_pend ? (wdata & bmask) : '0;
    pend_d = (pend_q & ~clr) | (evt & SRC_MASK[W-1:0]);
    en_d   = wr_en ? ((en_q & ~bmask) | (wdata & bmask)) : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      irq_q  <= |(pend_d & en_d);
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;

  // R8: a bit written with one and without a concurrent event is cleared
  assert_w1c_R8: assert property (@(posedge clk) disable iff (rst)
    wr_pend |=> ((pend_q & $past(wdata & bmask & ~evt)) == '0));
  // R9: an implemented event always leaves its bit set, even under a clear
  assert_evt_wins_R9: assert property (@(posedge clk) disable iff (rst)
    ((evt & SRC_MASK[W-1:0]) != '0) |=>
      ((pend_q & $past(evt & SRC_MASK[W-1:0])) == $past(evt & SRC_MASK[W-1:0])));
  // R7: unimplemented sources never show as pending
  assert_no_stray_R7: assert property (@(posedge clk) disable iff (rst)
    (pend_q & ~SRC_MASK[W-1:0]) == '0);
  // R10: the line is high only with an enabled pending bit
  assert_irq_src_R10: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> ((pend_q & en_q) != '0));
endmodule

// File: rtl/idx_regwin.sv
module idx_regwin #(
  parameter int          CH_W       = 2,
  parameter int          RA_W       = 12,
  parameter int          IMPL_DEPTH = 64,
  parameter logic [31:0] SRC_MASK   = 32'h0003_081F
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic [1:0]  host_addr,
  input  logic [3:0]  host_wstrb,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_rvalid,
  input  logic [31:0] evt_pulse,
  output logic        irq_o
);
  import regwin_pkg::*;

  localparam int NUM_CH = 1 << CH_W;
  localparam int BA_W   = $clog2(IMPL_DEPTH);
  localparam int RA_LSB = 16;

  win_sel_e    sel;
  logic [31:0] bmask;
  logic [CH_W-1:0] ch;
  logic [RA_W-1:0] ra;
  logic        in_range;
  logic        wr_data, rd_data;
  logic [NUM_CH-1:0] bank_we;
  logic [31:0] bank_rq [NUM_CH];
  logic [31:0] pend, en, ptr_word;

  assign sel      = win_sel_e'(host_addr);
  assign bmask    = lanes_to_bits(host_wstrb);
  assign in_range = (ra < RA_W'(IMPL_DEPTH));
  assign wr_data  = host_wr && (sel == WIN_DATA);
  assign rd_data  = host_rd && (sel == WIN_DATA);

  always_comb begin
    ptr_word = '0;
    ptr_word[CH_W-1:0] = ch;
    ptr_word[RA_LSB +: RA_W] = ra;
  end

  regwin_ptr #(.CH_W(CH_W), .RA_W(RA_W)) ptr_i (
    .clk      (clk),
    .rst      (rst),
    .we       (host_wr && (sel == WIN_PTR)),
    .ch_wmask (bmask[CH_W-1:0]),
    .ch_wdata (host_wdata[CH_W-1:0]),
    .ra_wmask (bmask[RA_LSB +: RA_W]),
    .ra_wdata (host_wdata[RA_LSB +: RA_W]),
    .ch_o     (ch),
    .ra_o     (ra)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
    assign bank_we[c] = wr_data && in_range && (ch == CH_W'(c));
    regwin_bank #(.DW(32), .DEPTH(IMPL_DEPTH)) bank_i (
      .clk (clk),
      .rst (rst),
      .we  (bank_we[c]),
      .wa  (ra[BA_W-1:0]),
      .wd  (host_wdata),
      .re  (rd_data),
      .ra  (ra[BA_W-1:0]),
      .rq  (bank_rq[c])
    );
  end

  regwin_irq #(.W(32), .SRC_MASK(SRC_MASK)) irq_i (
    .clk     (clk),
    .rst     (rst),
    .wr_pend (host_wr && (sel == WIN_PEND)),
    .wr_en   (host_wr && (sel == WIN_EN)),
    .bmask   (bmask),
    .wdata   (host_wdata),
    .evt     (evt_pulse),
    .pend_o  (pend),
    .en_o    (en),
    .irq_o   (irq_o)
  );

  // Read capture: direct words registered, indexed word from the banks
  win_sel_e    rsel_q;
  logic [31:0] rdir_q;
  logic [CH_W-1:0] rch_q;
  logic        rin_q, rvalid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q   <= WIN_PTR;
      rdir_q   <= '0;
      rch_q    <= '0;
      rin_q    <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= host_rd;
      if (host_rd) begin
        rsel_q <= sel;
        rch_q  <= ch;
        rin_q  <= in_range;
        unique case (sel)
          WIN_PTR:  rdir_q <= ptr_word;
          WIN_PEND: rdir_q <= pend;
          WIN_EN:   rdir_q <= en;
          default:  rdir_q <= '0;
        endcase
      end
    end
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = (rsel_q == WIN_DATA) ? (rin_q ? bank_rq[rch_q] : '0) : rdir_q;

  // R2: every read request is answered on the next cycle
  assert_rvalid_R2: assert property (@(posedge clk) disable iff (rst)
    host_rd |=> host_rvalid);
  // R5: at most one channel bank takes a write
  assert_bank_onehot_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bank_we));
  // R6: unimplemented indexed addresses read as zero
  assert_unimpl_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !in_range) |=> (host_rdata == '0));
endmodule

// File: tb/idx_regwin_tb_top.sv
module idx_regwin_tb_top;
  localparam logic [31:0] MASK = 32'h0003_081F;

  logic        clk = 1'b0;
  logic        rst;
  logic        host_wr, host_rd;
  logic [1:0]  host_addr;
  logic [3:0]  host_wstrb;
  logic [31:0] host_wdata, host_rdata, evt_pulse;
  logic        host_rvalid, irq_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  idx_regwin dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wstrb(host_wstrb), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .evt_pulse(evt_pulse), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] s, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wstrb = s; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_wstrb = 4'h0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata; v = host_rvalid;
  endtask

  task automatic set_ptr(input int ch, input int ra);
    wr(2'd0, 4'hF, {4'h0, 12'(ra), 14'h0, 2'(ch)});
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk);
    evt_pulse = e;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  function automatic logic [31:0] pat(input int ch, input int a);
    return 32'h5A00_0000 ^ (32'(ch) << 20) ^ (32'(a) << 8) ^ 32'(a * 7 + ch);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic v;
    rst = 1'b1; host_wr = 0; host_rd = 0; host_addr = 0; host_wstrb = 0;
    host_wdata = 0; evt_pulse = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    chk("R1 irq after reset", 32'(irq_o), 0);
    for (int a = 0; a < 4; a++) begin
      if (a == 1) continue;
      rd(2'(a), d, v);
      chk("R1 direct word reset", d, 0);
      chk("R2 rvalid", 32'(v), 1);
    end
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 64; a++) begin
        set_ptr(c, a); rd(2'd1, d, v);
        chk("R1 indexed word reset", d, 0);
      end

    // R3: pointer lanes
    wr(2'd0, 4'hF, 32'h0ABC_0003); rd(2'd0, d, v); chk("R3 ptr full", d, 32'h0ABC_0003);
    wr(2'd0, 4'h1, 32'hFFFF_FF01); rd(2'd0, d, v); chk("R3 ptr lane0", d, 32'h0ABC_0001);
    wr(2'd0, 4'h8, 32'h0500_0000); rd(2'd0, d, v); chk("R3 ptr lane3", d, 32'h05BC_0001);
    wr(2'd0, 4'h4, 32'h0012_0000); rd(2'd0, d, v); chk("R3 ptr lane2", d, 32'h0512_0001);
    wr(2'd0, 4'h2, 32'hFFFF_FFFF); rd(2'd0, d, v); chk("R3 ptr lane1 ignored", d, 32'h0512_0001);
    wr(2'd0, 4'hF, 32'hF123_4562); rd(2'd0, d, v); chk("R3 ptr unused bits", d, 32'h0123_0002);

    // R4/R5: full sweep of channels and addresses
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 64; a++) begin
        set_ptr(c, a); wr(2'd1, 4'hF, pat(c, a));
      end
    for (int c = 0; c < 4; c++)
      for (int a = 0; a < 64; a++) begin
        set_ptr(c, a); rd(2'd1, d, v);
        chk("R5 banked word", d, pat(c, a));
      end
    // R4: partial strobes still write the whole word
    set_ptr(2, 9); wr(2'd1, 4'h1, 32'hCAFE_F00D); rd(2'd1, d, v);
    chk("R4 full-word write", d, 32'hCAFE_F00D);
    for (int c = 0; c < 4; c++) begin
      if (c == 2) continue;
      set_ptr(c, 9); rd(2'd1, d, v);
      chk("R5 other channel kept", d, pat(c, 9));
    end

    // R6: unimplemented addresses, no aliasing
    for (int k = 0; k < 4; k++) begin
      int ua;
      ua = (k == 0) ? 12'h040 : (k == 1) ? 12'h100 : (k == 2) ? 12'hFC5 : 12'hFFF;
      set_ptr(1, ua); wr(2'd1, 4'hF, 32'hDEAD_BEEF); rd(2'd1, d, v);
      chk("R6 unimpl reads zero", d, 0);
      set_ptr(1, ua & 63); rd(2'd1, d, v);
      chk("R6 no alias", d, pat(1, ua & 63));
    end

    // R7/R8: every event bit, then clear
    for (int b = 0; b < 32; b++) begin
      pulse(32'h1 << b); rd(2'd2, d, v);
      chk("R7 event sets pending", d, (32'h1 << b) & MASK);
      wr(2'd2, 4'hF, 32'h1 << b); rd(2'd2, d, v);
      chk("R8 w1c clears", d, 0);
    end
    pulse(32'h0001_0001);
    wr(2'd2, 4'h1, 32'h0001_0001); rd(2'd2, d, v);
    chk("R8 lane-gated clear", d, 32'h0001_0000);
    wr(2'd2, 4'hF, 32'h0); rd(2'd2, d, v);
    chk("R8 zero write keeps", d, 32'h0001_0000);
    wr(2'd2, 4'hF, 32'h0001_0000);

    // R9: event beats concurrent clear
    pulse(32'h10);
    @(negedge clk);
    host_wr = 1; host_addr = 2'd2; host_wstrb = 4'hF; host_wdata = 32'h18; evt_pulse = 32'h8;
    @(negedge clk);
    host_wr = 0; host_wstrb = 0; evt_pulse = 0;
    rd(2'd2, d, v);
    chk("R9 event wins", d, 32'h8);

    // R10: interrupt line
    chk("R10 irq off with enable zero", 32'(irq_o), 0);
    wr(2'd3, 4'hF, 32'h8);
    chk("R10 irq on enable write", 32'(irq_o), 1);
    rd(2'd3, d, v); chk("R10 enable readback", d, 32'h8);
    wr(2'd2, 4'hF, 32'h8);
    chk("R10 irq off after clear", 32'(irq_o), 0);
    wr(2'd3, 4'h1, 32'h10);
    pulse(32'h1);
    chk("R10 masked event no irq", 32'(irq_o), 0);
    wr(2'd3, 4'hF, 32'hFFFF_FFFF);
    wr(2'd2, 4'hF, 32'hFFFF_FFFF);
    pulse(32'h0002_0000);
    chk("R10 irq same edge as event", 32'(irq_o), 1);
    wr(2'd3, 4'h4, 32'h0);
    chk("R10 irq off on lane disable", 32'(irq_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule